// File: doc/BRIEF.md
# NAND Identification Sequencer

This block reads the identification bytes of a NAND flash device over the usual parallel NAND pins. After a start pulse it selects the device and waits until the device reports ready. It then writes the identify command and one address byte. Next it reads ID bytes one at a time until it sees the expected maker code, or until it has used up a fixed number of tries.

Once the maker byte is found, or the tries run out, the block always reads four more bytes. These are the device code, the internal chip-number byte and two raw geometry bytes. It then deselects the device, pulses `done_o` for one cycle and holds the results until the next start. When the maker code never appears, the device code and chip number are reported as zero and the found flag stays low. The two geometry bytes are captured but not interpreted.

Top module: `nand_id_reader`

## Requirements
- R1: After reset `ce_n_o`, `we_n_o` and `re_n_o` are high, `cle_o` and `ale_o` are low, `done_o` and `found_o` are low, and `dev_code_o`, `chip_num_o` and `ext_id_o` are zero.
- R2: After a start, chip enable goes low. No write or read strobe occurs while the ready input is low. The sequence waits as long as needed for ready to go high.
- R3: The first bus writes are exactly two. The first is the identify command 0x90 with `cle_o` high. The second is one address byte 0x00 with `ale_o` high. Neither `cle_o` nor `ale_o` is high during reads.
- R4: The maker search reads bytes one by one and stops at the first byte equal to 0xEC. The total number of read strobes is the 1-based position of that byte plus four.
- R5: A maker byte at position 10, the last allowed try, is still found (`found_o` = 1, 14 reads).
- R6: If none of the first 10 bytes is 0xEC, the block makes 14 reads in total and reports `found_o` = 0, `dev_code_o` = 0x00 and `chip_num_o` = 0x00.
- R7: The four bytes read after the search map as follows: the first goes to `dev_code_o` and the second to `chip_num_o`. The third goes to `ext_id_o[7:0]` and the fourth to `ext_id_o[15:8]`. `ext_id_o` is loaded even when the maker code was missed.
- R8: `done_o` is high for exactly one cycle per sequence. In that cycle `ce_n_o` is already high and all result outputs carry their final values.
- R9: Results hold their values from `done_o` until the next accepted start. A start pulse during a running sequence is ignored and does not change the read count or cause a second `done_o`.
- R10: Each write or read strobe is low for exactly `PULSE_CYC` clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| rb_i | input | 1 | Device ready (1) / busy (0), asynchronous |
| io_i | input | 8 | Data bus from the device |
| ce_n_o | output | 1 | Chip enable, active low |
| cle_o | output | 1 | Command latch enable |
| ale_o | output | 1 | Address latch enable |
| we_n_o | output | 1 | Write strobe, active low |
| re_n_o | output | 1 | Read strobe, active low |
| io_oe_o | output | 1 | Drive enable for `io_o` |
| io_o | output | 8 | Data bus to the device |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| found_o | output | 1 | Maker code was seen |
| dev_code_o | output | 8 | Device code, zero on a miss |
| chip_num_o | output | 8 | Internal chip-number byte, zero on a miss |
| ext_id_o | output | 16 | Raw geometry bytes {fourth, third} |

## Verification
The hardest cases to reach from the ports are the edges of the search window: a maker byte on exactly the last allowed try, and a maker byte one position too late. Only the second of these must give a miss with zeroed outputs. The bench acts as the device. It serves a per-case byte stream and advances the stream on each falling read strobe. Moving 0xEC to position 10 and then to position 11 puts the sequencer on each side of the limit. A further case repeats 0xEC, so that a device code equal to the maker code shows that the search stops at the first match. Ready is held low for many cycles before each run, and a stray start is pulsed mid-scan.

// File: rtl/nand_id_pkg.sv
package nand_id_pkg;
  localparam int unsigned TAIL_BYTES = 4;
  localparam int unsigned TAIL_W     = $clog2(TAIL_BYTES);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CMD,
    ST_ADDR,
    ST_SCAN,
    ST_TAIL,
    ST_DONE
  } id_state_e;
endpackage

// File: rtl/nand_id_strobe_timer.sv
// Bus cycle: strobe active for PULSE_CYC cycles, then inactive for PULSE_CYC.
module nand_id_strobe_timer #(
  parameter int unsigned PULSE_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic strobe_o,
  output logic sample_o,
  output logic end_o
);
  localparam int unsigned CYC_LEN = 2 * PULSE_CYC;
  localparam int unsigned CW      = (CYC_LEN > 1) ? $clog2(CYC_LEN) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i)              cnt_q <= '0;
    else if (end_o)              cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end

  assign strobe_o = en_i && (cnt_q < CW'(PULSE_CYC));
  assign sample_o = en_i && (cnt_q == CW'(PULSE_CYC - 1));
  assign end_o    = en_i && (cnt_q == CW'(CYC_LEN - 1));
endmodule

// File: rtl/nand_id_capture.sv
module nand_id_capture
  import nand_id_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              wr_i,
  input  logic [TAIL_W-1:0] idx_i,
  input  logic [7:0]        data_i,
  input  logic              commit_i,
  input  logic              hit_i,
  output logic              found_o,
  output logic [7:0]        dev_o,
  output logic [7:0]        chip_o,
  output logic [15:0]       ext_o
);
  logic [7:0] raw_q [TAIL_BYTES];

  for (genvar g = 0; g < TAIL_BYTES; g++) begin : g_raw
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               raw_q[g] <= '0;
      else if (wr_i && idx_i == TAIL_W'(g))      raw_q[g] <= data_i;
    end
  end

  // last tail byte is written in the same cycle as commit only when PULSE_CYC is 0,
  // which the timer does not allow; commit reads settled raw bytes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      found_o <= 1'b0;
      dev_o   <= '0;
      chip_o  <= '0;
      ext_o   <= '0;
    end else if (clear_i) begin
      found_o <= 1'b0;
      dev_o   <= '0;
      chip_o  <= '0;
      ext_o   <= '0;
    end else if (commit_i) begin
      found_o <= hit_i;
      dev_o   <= hit_i ? raw_q[0] : 8'h00;
      chip_o  <= hit_i ? raw_q[1] : 8'h00;
      ext_o   <= {raw_q[3], raw_q[2]};
    end
  end
endmodule

// File: rtl/nand_id_reader.sv
module nand_id_reader
  import nand_id_pkg::*;
#(
  parameter logic [7:0]  MAKER_CODE  = 8'hEC,
  parameter int unsigned MAX_TRIES   = 10,
  parameter int unsigned PULSE_CYC   = 2,
  parameter logic [7:0]  CMD_READ_ID = 8'h90,
  parameter logic [7:0]  ID_ADDR     = 8'h00
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        rb_i,
  input  logic [7:0]  io_i,
  output logic        ce_n_o,
  output logic        cle_o,
  output logic        ale_o,
  output logic        we_n_o,
  output logic        re_n_o,
  output logic        io_oe_o,
  output logic [7:0]  io_o,
  output logic        done_o,
  output logic        found_o,
  output logic [7:0]  dev_code_o,
  output logic [7:0]  chip_num_o,
  output logic [15:0] ext_id_o
);
  localparam int unsigned TW = $clog2(MAX_TRIES + 1);

  id_state_e         state_q;
  logic [TW-1:0]     try_q;
  logic [TAIL_W-1:0] tail_q;
  logic              hit_q;
  logic [1:0]        rb_sync_q;
  logic              bus_en, strobe, sample, cyc_end;
  logic              is_wr, is_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rb_sync_q <= '0;
    else         rb_sync_q <= {rb_sync_q[0], rb_i};
  end

  assign is_wr  = (state_q == ST_CMD) || (state_q == ST_ADDR);
  assign is_rd  = (state_q == ST_SCAN) || (state_q == ST_TAIL);
  assign bus_en = is_wr || is_rd;

  nand_id_strobe_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (bus_en),
    .strobe_o (strobe),
    .sample_o (sample),
    .end_o    (cyc_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      try_q   <= '0;
      tail_q  <= '0;
      hit_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_WAIT;
          try_q   <= '0;
          tail_q  <= '0;
          hit_q   <= 1'b0;
        end
        ST_WAIT: if (rb_sync_q[1]) state_q <= ST_CMD;
        ST_CMD:  if (cyc_end) state_q <= ST_ADDR;
        ST_ADDR: if (cyc_end) state_q <= ST_SCAN;
        ST_SCAN: begin
          if (sample && io_i == MAKER_CODE) hit_q <= 1'b1;
          if (cyc_end) begin
            if (hit_q || try_q == TW'(MAX_TRIES - 1)) state_q <= ST_TAIL;
            else                                       try_q   <= try_q + 1'b1;
          end
        end
        ST_TAIL: if (cyc_end) begin
          if (tail_q == TAIL_W'(TAIL_BYTES - 1)) state_q <= ST_DONE;
          else                                   tail_q  <= tail_q + 1'b1;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  nand_id_capture u_capture (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (state_q == ST_IDLE && start_i),
    .wr_i     (state_q == ST_TAIL && sample),
    .idx_i    (tail_q),
    .data_i   (io_i),
    .commit_i (state_q == ST_TAIL && cyc_end && tail_q == TAIL_W'(TAIL_BYTES - 1)),
    .hit_i    (hit_q),
    .found_o  (found_o),
    .dev_o    (dev_code_o),
    .chip_o   (chip_num_o),
    .ext_o    (ext_id_o)
  );

  assign ce_n_o  = (state_q == ST_IDLE) || (state_q == ST_DONE);
  assign cle_o   = (state_q == ST_CMD);
  assign ale_o   = (state_q == ST_ADDR);
  assign we_n_o  = !(is_wr && strobe);
  assign re_n_o  = !(is_rd && strobe);
  assign io_oe_o = is_wr;
  assign io_o    = (state_q == ST_CMD)  ? CMD_READ_ID :
                   (state_q == ST_ADDR) ? ID_ADDR : 8'h00;
  assign done_o  = (state_q == ST_DONE);
endmodule

// File: rtl/nand_id_reader_chk.sv
module nand_id_reader_chk #(
  parameter int unsigned PULSE_CYC = 2
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        rb_i,
  input logic [7:0]  io_i,
  input logic        ce_n_o,
  input logic        cle_o,
  input logic        ale_o,
  input logic        we_n_o,
  input logic        re_n_o,
  input logic        io_oe_o,
  input logic [7:0]  io_o,
  input logic        done_o,
  input logic        found_o,
  input logic [7:0]  dev_code_o,
  input logic [7:0]  chip_num_o,
  input logic [15:0] ext_id_o
);
  logic [15:0] re_lo_cnt, we_lo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      re_lo_cnt <= '0;
      we_lo_cnt <= '0;
    end else begin
      re_lo_cnt <= re_n_o ? 16'd0 : re_lo_cnt + 16'd1;
      we_lo_cnt <= we_n_o ? 16'd0 : we_lo_cnt + 16'd1;
    end
  end

  a_r2_strobe_needs_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_n_o |-> (we_n_o && re_n_o));
  a_r3_latch_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cle_o && ale_o) && !(!re_n_o && (cle_o || ale_o)));
  a_r3_drive_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_n_o |-> io_oe_o);
  a_r6_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !found_o) |-> (dev_code_o == 8'h00 && chip_num_o == 8'h00));
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_done_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ce_n_o);
  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_n_o && $past(ce_n_o) && !done_o) |->
      ($stable(dev_code_o) && $stable(chip_num_o) && $stable(ext_id_o) && $stable(found_o)));
  a_r10_re_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_n_o && !$past(re_n_o)) |-> re_lo_cnt == 16'(PULSE_CYC));
  a_r10_we_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_n_o && !$past(we_n_o)) |-> we_lo_cnt == 16'(PULSE_CYC));
endmodule

bind nand_id_reader nand_id_reader_chk #(.PULSE_CYC(PULSE_CYC)) chk_i (.*);

// File: tb/nand_id_reader_tb_top.sv
module nand_id_reader_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        rb_i = 1'b0;
  logic [7:0]  io_i;
  logic        ce_n_o, cle_o, ale_o, we_n_o, re_n_o, io_oe_o, done_o, found_o;
  logic [7:0]  io_o, dev_code_o, chip_num_o;
  logic [15:0] ext_id_o;

  always #5 clk_i = ~clk_i;

  nand_id_reader dut_i (.*);

  typedef struct {
    logic        found;
    logic [7:0]  dev;
    logic [7:0]  chip;
    logic [15:0] ext;
    int          reads;
  } exp_t;

  exp_t        sb_q[$];
  exp_t        last_exp;
  logic [7:0]  stream [16];
  int          rd_cnt, we_cnt, done_cnt, early_we;
  logic [7:0]  we_data [4];
  logic        we_cle [4];
  logic        we_ale [4];
  logic        re_prev = 1'b1, we_prev = 1'b1;
  int          checks = 0, failures = 0;

  assign io_i = (rd_cnt == 0 || rd_cnt > 16) ? 8'hFF : stream[rd_cnt-1];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // device model and scoreboard monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (!we_n_o && we_prev) begin
        if (!rb_i) early_we++;
        if (we_cnt < 4) begin
          we_data[we_cnt] = io_o;
          we_cle[we_cnt]  = cle_o;
          we_ale[we_cnt]  = ale_o;
        end
        we_cnt++;
      end
      if (!re_n_o && re_prev) rd_cnt++;
      if (done_o) begin
        exp_t e;
        done_cnt++;
        if (sb_q.size() == 0) begin
          chk("R9 unexpected done", 1, 0);
        end else begin
          e = sb_q.pop_front();
          chk("R8 ce released at done", ce_n_o, 1);
          chk("R4 R5 R6 found flag", found_o, e.found);
          chk("R7 R6 device code", dev_code_o, e.dev);
          chk("R7 R6 chip number", chip_num_o, e.chip);
          chk("R7 extra id bytes", ext_id_o, e.ext);
          chk("R4 R5 R6 read count", rd_cnt, e.reads);
          chk("R3 write count", we_cnt, 2);
          chk("R3 command byte", {we_cle[0], we_ale[0], we_data[0]}, {2'b10, 8'h90});
          chk("R3 address byte", {we_cle[1], we_ale[1], we_data[1]}, {2'b01, 8'h00});
        end
      end
    end
    we_prev = we_n_o;
    re_prev = re_n_o;
  end

  task automatic run_case(input bit poke_busy);
    exp_t e;
    int   pos = -1;
    int   base;
    for (int i = 0; i < 10; i++) if (pos < 0 && stream[i] == 8'hEC) pos = i;
    base    = (pos < 0) ? 10 : pos + 1;
    e.found = (pos >= 0);
    e.dev   = e.found ? stream[base]   : 8'h00;
    e.chip  = e.found ? stream[base+1] : 8'h00;
    e.ext   = {stream[base+3], stream[base+2]};
    e.reads = base + 4;
    sb_q.push_back(e);
    last_exp = e;
    rd_cnt = 0; we_cnt = 0; early_we = 0;
    rb_i = 1'b0;
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    repeat (12) @(negedge clk_i);
    chk("R2 ce low while busy", ce_n_o, 0);
    chk("R2 no strobe while busy", early_we + rd_cnt, 0);
    rb_i = 1'b1;
    if (poke_busy) begin
      repeat (30) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i) start_i = 1'b0;
    end
    begin
      int d0 = done_cnt;
      while (done_cnt == d0) @(negedge clk_i);
      repeat (6) @(negedge clk_i);
      chk("R8 R9 single done", done_cnt, d0 + 1);
    end
  endtask

  task automatic fill(input logic [7:0] b);
    for (int i = 0; i < 16; i++) stream[i] = b + 8'(i * 7);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 ce_n", ce_n_o, 1);
    chk("R1 strobes", {we_n_o, re_n_o, cle_o, ale_o}, 4'b1100);
    chk("R1 flags", {done_o, found_o}, 2'b00);
    chk("R1 results", {dev_code_o, chip_num_o, ext_id_o}, 32'h0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R4: maker first
    fill(8'h01); stream[0] = 8'hEC; stream[1] = 8'h11; stream[2] = 8'h22;
    stream[3] = 8'h33; stream[4] = 8'h44;
    run_case(1'b0);
    // R4 R9: maker at 5th position, stray start mid-scan
    fill(8'h10); stream[4] = 8'hEC;
    run_case(1'b1);
    // R5: maker on last try
    fill(8'h20); stream[9] = 8'hEC;
    run_case(1'b0);
    // R6: maker one beyond the window
    fill(8'h30); stream[10] = 8'hEC;
    run_case(1'b0);
    // R6: no maker at all
    fill(8'h02);
    run_case(1'b0);
    // R4 R7: repeated maker, device code equals maker code
    fill(8'h40); stream[2] = 8'hEC; stream[3] = 8'hEC; stream[4] = 8'h5A;
    run_case(1'b0);

    // R9: results held while idle, bus activity ignored
    fill(8'h77);
    repeat (25) @(negedge clk_i);
    chk("R9 hold found", found_o, last_exp.found);
    chk("R9 hold device", dev_code_o, last_exp.dev);
    chk("R9 hold chip", chip_num_o, last_exp.chip);
    chk("R9 hold ext", ext_id_o, last_exp.ext);
    chk("R9 idle deselected", ce_n_o, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule